// File: doc/BRIEF.md
# Bulk-Erase Flash Command Controller

This block is the command front end of a flash array that can only be erased as a whole. A host writes command bytes with an active-low write strobe while chip select is low. The block acts on each command when the strobe goes high again. Erasing takes two writes: an arming byte, then the same byte again as confirmation. The confirmation starts an internal erase pulse. A hardware stop timer ends that pulse after a fixed number of clock cycles.

A separate verify command ends any erase still in progress and records the address given with it. After a settling delay, read cycles return the byte stored at that recorded address. The host uses this to check, byte by byte, that the erase took effect. The storage is a behavioural byte array. Reset loads it with a known pattern, and every byte is driven to FFh on each cycle that the erase pulse is active. Both timer lengths are parameters counted in clock cycles.

Top module: `flash_erase_cmd`

## Requirements
- R1: A write is accepted once, when `we_n` rises while `ce_n` is low, and uses the address and data that were present while `we_n` was low. After reset the block is in read mode, `busy` and `erase_on` are low, and the byte at address a holds (a mod 256) XOR 3Ch. In read mode, a read cycle (`ce_n` and `oe_n` both low) returns the byte at `addr`. `rdata` is 00h whenever `ce_n` or `oe_n` is high.
- R2: A single write of 20h only arms erase: `erase_on` stays low, and reads still return the unchanged array.
- R3: A write of 20h made directly after the arming write raises `erase_on` in the cycle after the strobe rises. While it is high, every byte becomes FFh, whatever address came with either write.
- R4: If no further command arrives, `erase_on` stays high for exactly ERASE_CYC cycles, and the block then returns to read mode.
- R5: A write of A0h while erase is running drops `erase_on` in the cycle after its strobe rises.
- R6: Any byte other than 20h written while erase is armed cancels the arming and returns to read mode, so a later single 20h arms erase again but does not start it.
- R7: A write of A0h made in read, erase, settle or verify mode records its address and keeps `busy` high for exactly SETTLE_CYC cycles. After that, read cycles return the byte at the recorded address, whatever is on `addr`.
- R8: `busy` is high exactly while erase or settling is in progress, and read cycles return 00h during that time.
- R9: In verify mode, a write of 20h arms erase, a write of A0h restarts settling, and any other byte returns the block to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable for read cycles, active low |
| we_n | input | 1 | Write strobe, active low; a command is taken on its rising edge |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| wdata | input | 8 | Command byte |
| rdata | output | 8 | Read data, 00h when not reading or while busy |
| busy | output | 1 | High while erase or settling is in progress |
| erase_on | output | 1 | Internal erase pulse |

## Verification
The bench builds the block with a 40-cycle stop timer, a 12-cycle settling delay and a 16-byte array. With these values, a full unattended erase, its exact last cycle and the first cycle after it can all be reached within a few hundred clocks. An erase can also be cut short by the verify command well before the stop timer expires. The settling window is short enough to probe its last busy cycle and its first valid verify read. Because each reset restores the seeded pattern, a verify read at a recorded address can be told apart from a read at the address on the bus.

// File: rtl/erase_cmd_pkg.sv
package erase_cmd_pkg;
    typedef enum logic [2:0] {
        ST_READ,
        ST_SETUP,
        ST_ERASE,
        ST_SETTLE,
        ST_VERIFY
    } mode_e;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_VERIFY  = 8'hA0;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam logic [7:0] SEED_MASK   = 8'h3C;
endpackage

// File: rtl/erase_wr_strobe.sv
// Captures address and data while the write strobe is low and signals one
// accepted write when the strobe rises with chip select still low.
module erase_wr_strobe #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          wr_evt,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    typedef struct packed {
        logic          armed;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ce_n && !we_n) begin
            st_d.armed = 1'b1;
            st_d.addr  = addr;
            st_d.data  = wdata;
        end else if (we_n) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_evt  = st_q.armed && we_n && !ce_n;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;

    AST_ONE_WRITE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R1
endmodule

// File: rtl/erase_mode_ctrl.sv
// Command sequencer: erase arming, confirmed erase with stop timer,
// verify command with settling delay.
module erase_mode_ctrl
    import erase_cmd_pkg::*;
#(
    parameter int AW         = 4,
    parameter int ERASE_CYC  = 500000,
    parameter int SETTLE_CYC = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_evt,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          erase_on,
    output logic          busy,
    output logic          read_ok,
    output logic          verify_rd,
    output logic [AW-1:0] vaddr
);
    localparam int MAXC = (ERASE_CYC > SETTLE_CYC) ? ERASE_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        mode_e         mode;
        logic [CW-1:0] cnt;
        logic [AW-1:0] vaddr;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.mode)
            ST_READ: begin
                if (wr_evt) begin
                    if (wr_data == CMD_ERASE) begin
                        nxt_d.mode = ST_SETUP;
                    end else if (wr_data == CMD_VERIFY) begin
                        nxt_d.mode  = ST_SETTLE;
                        nxt_d.cnt   = CW'(SETTLE_CYC);
                        nxt_d.vaddr = wr_addr;
                    end
                end
            end
            ST_SETUP: begin
                if (wr_evt) begin
                    if (wr_data == CMD_ERASE) begin
                        nxt_d.mode = ST_ERASE;
                        nxt_d.cnt  = CW'(ERASE_CYC);
                    end else begin
                        nxt_d.mode = ST_READ;
                    end
                end
            end
            ST_ERASE: begin
                if (wr_evt && wr_data == CMD_VERIFY) begin
                    nxt_d.mode  = ST_SETTLE;
                    nxt_d.cnt   = CW'(SETTLE_CYC);
                    nxt_d.vaddr = wr_addr;
                end else if (cur_q.cnt == CW'(1)) begin
                    nxt_d.mode = ST_READ;
                end else begin
                    nxt_d.cnt = cur_q.cnt - CW'(1);
                end
            end
            ST_SETTLE, ST_VERIFY: begin
                if (wr_evt) begin
                    if (wr_data == CMD_ERASE) begin
                        nxt_d.mode = ST_SETUP;
                    end else if (wr_data == CMD_VERIFY) begin
                        nxt_d.mode  = ST_SETTLE;
                        nxt_d.cnt   = CW'(SETTLE_CYC);
                        nxt_d.vaddr = wr_addr;
                    end else begin
                        nxt_d.mode = ST_READ;
                    end
                end else if (cur_q.mode == ST_SETTLE) begin
                    if (cur_q.cnt == CW'(1)) begin
                        nxt_d.mode = ST_VERIFY;
                    end else begin
                        nxt_d.cnt = cur_q.cnt - CW'(1);
                    end
                end
            end
            default: nxt_d.mode = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.mode  <= ST_READ;
            cur_q.cnt   <= '0;
            cur_q.vaddr <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign erase_on  = (cur_q.mode == ST_ERASE);
    assign busy      = (cur_q.mode == ST_ERASE) || (cur_q.mode == ST_SETTLE);
    assign read_ok   = (cur_q.mode == ST_READ) || (cur_q.mode == ST_SETUP);
    assign verify_rd = (cur_q.mode == ST_VERIFY);
    assign vaddr     = cur_q.vaddr;

    // Independent run-length counter for the stop-timer bound.
    logic [CW:0] erase_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_run_q <= '0;
        end else if (erase_on) begin
            erase_run_q <= erase_run_q + 1'b1;
        end else begin
            erase_run_q <= '0;
        end
    end

    AST_ERASE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_on |-> (erase_run_q < (CW+1)'(ERASE_CYC))); // R4
    AST_ERASE_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_on) |-> $past(wr_evt && wr_data == CMD_ERASE && cur_q.mode == ST_SETUP)); // R3
    AST_ARM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == ST_READ && wr_evt) |=> !erase_on); // R2
    AST_VERIFY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && wr_data == CMD_VERIFY && cur_q.mode != ST_SETUP) |=> (!erase_on && busy)); // R5
    AST_BUSY_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_on |-> busy); // R8
    AST_IDLE_IN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        verify_rd |-> !busy); // R8
endmodule

// File: rtl/erase_cell_model.sv
// Behavioural byte store: seeded at reset, all bytes forced to the erased
// value on every cycle the erase pulse is active.
module erase_cell_model
    import erase_cmd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_on,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = erase_on ? ERASED_BYTE : mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'(i) ^ SEED_MASK;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_byte = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr] : 8'h00;

    AST_ALL_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(erase_on) |-> (mem_q[0] == ERASED_BYTE && mem_q[DEPTH-1] == ERASED_BYTE)); // R3
endmodule

// File: rtl/flash_erase_cmd.sv
module flash_erase_cmd #(
    parameter int DEPTH      = 16,
    parameter int ERASE_CYC  = 500000,
    parameter int SETTLE_CYC = 300,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          busy,
    output logic          erase_on
);
    logic          wr_evt;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          read_ok;
    logic          verify_rd;
    logic [AW-1:0] vaddr;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_byte;

    erase_wr_strobe #(.AW(AW)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_evt  (wr_evt),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    erase_mode_ctrl #(
        .AW         (AW),
        .ERASE_CYC  (ERASE_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .erase_on  (erase_on),
        .busy      (busy),
        .read_ok   (read_ok),
        .verify_rd (verify_rd),
        .vaddr     (vaddr)
    );

    erase_cell_model #(.DEPTH(DEPTH), .AW(AW)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_on (erase_on),
        .rd_addr  (rd_addr),
        .rd_byte  (rd_byte)
    );

    always_comb begin
        rd_addr = verify_rd ? vaddr : addr;
        if (!ce_n && !oe_n && (read_ok || verify_rd)) begin
            rdata = rd_byte;
        end else begin
            rdata = 8'h00;
        end
    end
endmodule

// File: tb/test_flash_erase_cmd.sv
module test_flash_erase_cmd;
    localparam int DEPTH      = 16;
    localparam int ERASE_CYC  = 40;
    localparam int SETTLE_CYC = 12;
    localparam int AW         = 4;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n  = 1'b1;
    logic          oe_n  = 1'b1;
    logic          we_n  = 1'b1;
    logic [AW-1:0] addr  = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          busy;
    logic          erase_on;

    always #10 clk = ~clk;

    flash_erase_cmd #(
        .DEPTH      (DEPTH),
        .ERASE_CYC  (ERASE_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) i_flash_erase_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .busy     (busy),
        .erase_on (erase_on)
    );

    // sig: 0 = rdata, 1 = busy, 2 = erase_on
    typedef struct {
        int         due;
        int         sig;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    int    cyc    = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops every item due in this cycle and compares.
    always @(negedge clk) begin
        item_t      it;
        logic [7:0] act;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            it = sb_q.pop_front();
            case (it.sig)
                0:       act = rdata;
                1:       act = {7'b0, busy};
                default: act = {7'b0, erase_on};
            endcase
            checks++;
            if (it.due < cyc) begin
                errors++;
                $display("FAIL %s: check missed at cycle %0d (due %0d)", it.req, cyc, it.due);
            end else if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: sig %0d actual %02h expected %02h at cycle %0d",
                         it.req, it.sig, act, it.exp, cyc);
            end
        end
    end

    function automatic logic [7:0] seed(input int a);
        return 8'(a) ^ 8'h3C;
    endfunction

    task automatic expect_at(input int due, input int sig, input logic [7:0] exp, input string req);
        item_t it;
        int    pos;
        it.due = due; it.sig = sig; it.exp = exp; it.req = req;
        pos = sb_q.size();
        for (int k = 0; k < sb_q.size(); k++) begin
            if (sb_q[k].due > due) begin
                pos = k;
                break;
            end
        end
        sb_q.insert(pos, it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    // Returns in the first cycle after the command took effect.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        tick();
        we_n = 1'b1;
        tick();
        ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        expect_at(cyc, 0, exp, req);
        tick();
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        int s;
        do_reset();

        // R1: reset state and plain reads
        expect_at(cyc, 1, 8'h00, "R1 busy after reset");
        expect_at(cyc, 2, 8'h00, "R1 erase_on after reset");
        rd(4'd3, seed(3), "R1");
        rd(4'd10, seed(10), "R1");
        ce_n = 1'b0; oe_n = 1'b1; addr = 4'd3;
        expect_at(cyc, 0, 8'h00, "R1 oe_n high");
        tick();
        ce_n = 1'b1;

        // R2: single arming write
        wr(4'd5, 8'h20);
        expect_at(cyc, 2, 8'h00, "R2 erase_on");
        rd(4'd3, seed(3), "R2");

        // R6: cancel, then a lone 20h only re-arms
        wr(4'd0, 8'h55);
        wr(4'd0, 8'h20);
        expect_at(cyc, 2, 8'h00, "R6 erase_on");
        rd(4'd4, seed(4), "R6");
        wr(4'd0, 8'h00);

        // R3/R4: full erase run to the stop timer
        wr(4'd9, 8'h20);
        wr(4'd2, 8'h20);
        s = cyc;
        expect_at(s, 2, 8'h01, "R3 erase_on");
        expect_at(s, 1, 8'h01, "R8 busy in erase");
        expect_at(s + ERASE_CYC - 1, 2, 8'h01, "R4 last erase cycle");
        expect_at(s + ERASE_CYC, 2, 8'h00, "R4 stop timer");
        expect_at(s + ERASE_CYC, 1, 8'h00, "R8 busy after erase");
        rd(4'd6, 8'h00, "R8 read while busy");
        wait_until(s + ERASE_CYC + 1);
        rd(4'd2, 8'hFF, "R3");
        rd(4'd13, 8'hFF, "R3");
        rd(4'd0, 8'hFF, "R4 back in read mode");

        // R5/R7: verify cuts erase short
        do_reset();
        rd(4'd7, seed(7), "R1 reset restores");
        wr(4'd1, 8'h20);
        wr(4'd1, 8'h20);
        repeat (10) tick();
        wr(4'd7, 8'hA0);
        s = cyc;
        expect_at(s, 2, 8'h00, "R5 erase_on");
        expect_at(s, 1, 8'h01, "R7 busy settle");
        rd(4'd3, 8'h00, "R7 read while settling");
        expect_at(s + SETTLE_CYC - 1, 1, 8'h01, "R7 last settle cycle");
        expect_at(s + SETTLE_CYC, 1, 8'h00, "R7 settle done");
        wait_until(s + SETTLE_CYC);
        rd(4'd4, 8'hFF, "R7 verify read");

        // R9: from verify, 20h 20h erases again
        wr(4'd0, 8'h20);
        expect_at(cyc, 2, 8'h00, "R9 arm from verify");
        wr(4'd0, 8'h20);
        expect_at(cyc, 2, 8'h01, "R9 erase from verify");
        wr(4'd2, 8'hA0);
        expect_at(cyc, 2, 8'h00, "R5 second stop");

        // R7/R9: verify from read mode at a seeded address
        do_reset();
        wr(4'd6, 8'hA0);
        s = cyc;
        expect_at(s, 1, 8'h01, "R7 busy");
        wait_until(s + SETTLE_CYC);
        rd(4'd1, seed(6), "R7 recorded address");
        wr(4'd0, 8'h11);
        rd(4'd1, seed(1), "R9 other byte to read mode");

        // R1: reset during verify returns to read mode
        wr(4'd6, 8'hA0);
        wait_until(cyc + SETTLE_CYC + 1);
        do_reset();
        expect_at(cyc, 1, 8'h00, "R1 busy after reset");
        rd(4'd1, seed(1), "R1 read after reset");

        repeat (3) tick();
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule